// File: doc/BRIEF.md
# SCL Timing Generator

This block turns a fast source clock into the clock-line waveform of an I2C bus master. The source clock is first slowed by a programmable divider, and every phase length is counted in the slower ticks. The released (high) part of each bus-clock period and the driven-low part of the same period each come from their own counts. A third count gives the total period; when the high and low counts add up to less than the total, the low part is stretched to fill the gap. All three counts come either from separate input buses or from one packed configuration word.

Beside the clock-line level, the block gives the command sequencer four single-cycle strobes. Two mark the line being pulled low and being released. The third marks the middle of the low part, where data may change, and the fourth marks the middle of the high part, where data is sampled. The high part is only counted while the returned clock line actually reads high, so a target that holds the clock low stretches the period. Raising the enable input starts clocking. Dropping it lets the current period run to the end of its high part, after which the line stays released.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, with enable low, `scl_out` is 1 and all four strobes are 0.
- R2: A phase of N ticks lasts N × D source-clock cycles, where D is `div_val`; a `div_val` of 0 behaves as 1.
- R3: The low phase lasts Le ticks. Le is `cycle − high` when `high + low < cycle`, and otherwise it is `low`. Le is never less than 2.
- R4: The high phase lasts max(`high`, 2) ticks, counted only while `scl_in` reads 1.
- R5: When `cfg_packed_sel` is 1, the counts come from `cfg_word`: high from bits 29:20, low from bits 19:10 and cycle from bits 9:0. The discrete count inputs are then ignored. The divider always comes from `div_val`.
- R6: In the cycle where `scl_out` first reads 0, `scl_fall` is 1 for exactly one cycle. In the cycle where `scl_out` first reads 1 again, `scl_rise` is 1 for exactly one cycle. From idle, the first `scl_fall` appears one clock edge after enable is sampled high.
- R7: `sda_change` pulses floor(Le/2) × D cycles after `scl_fall`. `sda_sample` pulses floor(He/2) × D cycles after high-phase counting starts, where He is the high length from R4.
- R8: While `scl_out` is 1 in an active period and `scl_in` reads 0, both the high-phase count and the divider hold. Each held cycle delays the later strobes by one cycle.
- R9: Enable is sampled at the end of each high phase. If it is low there, `scl_out` stays 1 and no further `scl_fall` occurs.
- R10: The counts and the divider are captured at each `scl_fall`. A change made in the middle of a period takes effect only in the next period.
- R11: At most one of the four strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run bus clocking |
| cfg_packed_sel | input | 1 | 1: take the counts from `cfg_word` |
| cfg_word | input | 3*CNT_W | Packed counts: high, low, cycle |
| div_val | input | DIV_W | Source-clock divider |
| high_val | input | CNT_W | High-phase tick count |
| low_val | input | CNT_W | Low-phase tick count |
| cycle_val | input | CNT_W | Total period tick count |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_out | output | 1 | Clock-line drive: 0 pulls low, 1 releases |
| scl_fall | output | 1 | Strobe at the start of the low level |
| scl_rise | output | 1 | Strobe at the release of the line |
| sda_change | output | 1 | Strobe at mid-low, where data may change |
| sda_sample | output | 1 | Strobe at mid-high, where data is sampled |

## Verification
A phase counter or divider that slips by one tick moves every later strobe by a whole divider period. That error shows in the spacing between the fall and rise strobes within the first period after enable. A captured count that is wrong, or taken at the wrong time, shows in the second period's mid-high strobe. A state machine that fails to park shows as a third falling strobe or a low line within one high phase after enable drops. A stuck stretch hold shows as a high phase that never ends, which the per-case cycle limit catches.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // Phase of the bus-clock waveform
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Number of count fields in the packed configuration word
  localparam int CFG_FIELDS = 3;

  // Field index inside the packed word, lowest field first
  localparam int FLD_CYCLE = 0;
  localparam int FLD_LOW   = 1;
  localparam int FLD_HIGH  = 2;

  // Shortest phase in ticks, so a mid point always lies strictly inside a phase
  localparam int MIN_PHASE_TICKS = 2;

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture,
  input  logic                      use_word,
  input  logic [CFG_FIELDS*CNT_W-1:0] word,
  input  logic [DIV_W-1:0]          div_in,
  input  logic [CNT_W-1:0]          high_in,
  input  logic [CNT_W-1:0]          low_in,
  input  logic [CNT_W-1:0]          cycle_in,
  output logic [DIV_W-1:0]          div_last,
  output logic [CNT_W-1:0]          high_last,
  output logic [CNT_W-1:0]          low_last,
  output logic [CNT_W-1:0]          high_mid,
  output logic [CNT_W-1:0]          low_mid
);

  localparam logic [CNT_W-1:0] MIN_PH = CNT_W'(MIN_PHASE_TICKS);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] fld [CFG_FIELDS];

  genvar g;
  generate
    for (g = 0; g < CFG_FIELDS; g++) begin : g_unpack
      assign fld[g] = word[g*CNT_W +: CNT_W];
    end
  endgenerate

  logic [CNT_W-1:0] h_sel, l_sel, c_sel;
  logic [CNT_W:0]   hl_sum;
  logic [CNT_W-1:0] l_ext, h_eff, l_eff;
  logic [DIV_W-1:0] div_last_d;
  logic [CNT_W-1:0] high_last_d, low_last_d, high_mid_d, low_mid_d;

  always_comb begin
    h_sel  = use_word ? fld[FLD_HIGH]  : high_in;
    l_sel  = use_word ? fld[FLD_LOW]   : low_in;
    c_sel  = use_word ? fld[FLD_CYCLE] : cycle_in;
    hl_sum = {1'b0, h_sel} + {1'b0, l_sel};
    // leftover ticks of the period lengthen the low phase
    l_ext  = (hl_sum < {1'b0, c_sel}) ? (c_sel - h_sel) : l_sel;
    h_eff  = (h_sel < MIN_PH) ? MIN_PH : h_sel;
    l_eff  = (l_ext < MIN_PH) ? MIN_PH : l_ext;
    div_last_d  = (div_in == '0) ? '0 : (div_in - DIV_W'(1));
    high_last_d = h_eff - ONE;
    low_last_d  = l_eff - ONE;
    high_mid_d  = (h_eff >> 1) - ONE;
    low_mid_d   = (l_eff >> 1) - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_last  <= '0;
      high_last <= ONE;
      low_last  <= ONE;
      high_mid  <= '0;
      low_mid   <= '0;
    end else if (capture) begin
      div_last  <= div_last_d;
      high_last <= high_last_d;
      low_last  <= low_last_d;
      high_mid  <= high_mid_d;
      low_mid   <= low_mid_d;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_last,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div_last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] high_last,
  input  logic [CNT_W-1:0] low_last,
  input  logic [CNT_W-1:0] high_mid,
  input  logic [CNT_W-1:0] low_mid,
  output logic             run,
  output logic             idle,
  output logic             capture,
  output logic             scl_out,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_low_stb,
  output logic             mid_high_stb
);

  scl_phase_e       st_q, st_d;
  logic [CNT_W-1:0] pc_q, pc_d;
  logic             fall_d, rise_d, ml_d, mh_d;

  assign run  = (st_q == PH_LOW) || ((st_q == PH_HIGH) && scl_in);
  assign idle = (st_q == PH_IDLE);

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    fall_d  = 1'b0;
    rise_d  = 1'b0;
    ml_d    = 1'b0;
    mh_d    = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (enable) begin
          st_d    = PH_LOW;
          pc_d    = '0;
          fall_d  = 1'b1;
          capture = 1'b1;
        end
      end
      PH_LOW: begin
        if (tick) begin
          if (pc_q == low_last) begin
            st_d   = PH_HIGH;
            pc_d   = '0;
            rise_d = 1'b1;
          end else begin
            pc_d = pc_q + CNT_W'(1);
            ml_d = (pc_q == low_mid);
          end
        end
      end
      PH_HIGH: begin
        if (tick) begin
          if (pc_q == high_last) begin
            pc_d = '0;
            if (enable) begin
              st_d    = PH_LOW;
              fall_d  = 1'b1;
              capture = 1'b1;
            end else begin
              st_d = PH_IDLE;
            end
          end else begin
            pc_d = pc_q + CNT_W'(1);
            mh_d = (pc_q == high_mid);
          end
        end
      end
      default: begin
        st_d = PH_IDLE;
        pc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= PH_IDLE;
      pc_q         <= '0;
      scl_out      <= 1'b1;
      fall_stb     <= 1'b0;
      rise_stb     <= 1'b0;
      mid_low_stb  <= 1'b0;
      mid_high_stb <= 1'b0;
    end else begin
      st_q         <= st_d;
      pc_q         <= pc_d;
      scl_out      <= (st_d != PH_LOW);
      fall_stb     <= fall_d;
      rise_stb     <= rise_d;
      mid_low_stb  <= ml_d;
      mid_high_stb <= mh_d;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        cfg_packed_sel,
  input  logic [CFG_FIELDS*CNT_W-1:0] cfg_word,
  input  logic [DIV_W-1:0]            div_val,
  input  logic [CNT_W-1:0]            high_val,
  input  logic [CNT_W-1:0]            low_val,
  input  logic [CNT_W-1:0]            cycle_val,
  input  logic                        scl_in,
  output logic                        scl_out,
  output logic                        scl_fall,
  output logic                        scl_rise,
  output logic                        sda_change,
  output logic                        sda_sample
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic             run, idle, capture, tick;
  logic [DIV_W-1:0] div_last;
  logic [CNT_W-1:0] high_last, low_last, high_mid, low_mid;

  scl_cfg_shadow #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .capture   (capture),
    .use_word  (cfg_packed_sel),
    .word      (cfg_word),
    .div_in    (div_val),
    .high_in   (high_val),
    .low_in    (low_val),
    .cycle_in  (cycle_val),
    .div_last  (div_last),
    .high_last (high_last),
    .low_last  (low_last),
    .high_mid  (high_mid),
    .low_mid   (low_mid)
  );

  scl_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .clr      (idle),
    .div_last (div_last),
    .tick     (tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .enable       (enable),
    .scl_in       (scl_in),
    .tick         (tick),
    .high_last    (high_last),
    .low_last     (low_last),
    .high_mid     (high_mid),
    .low_mid      (low_mid),
    .run          (run),
    .idle         (idle),
    .capture      (capture),
    .scl_out      (scl_out),
    .fall_stb     (scl_fall),
    .rise_stb     (scl_rise),
    .mid_low_stb  (sda_change),
    .mid_high_stb (sda_sample)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_out,
  input logic scl_fall,
  input logic scl_rise,
  input logic sda_change,
  input logic sda_sample
);

  // R6: a fall strobe is only seen with the line low
  assert_fall_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_out);

  // R6: a rise strobe is only seen with the line released
  assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> scl_out);

  // R6: every high-to-low change of the line carries the fall strobe
  assert_fell_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> scl_fall);

  // R6: every low-to-high change of the line carries the rise strobe
  assert_rose_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_out) |-> scl_rise);

  // R7: the data-change point lies inside the low phase
  assert_mid_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> !scl_out);

  // R7: the data-sample point lies inside the high phase
  assert_mid_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample |-> scl_out);

  // R9: with enable low, a released line is never pulled low again
  assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_out && !enable) |=> scl_out);

  // R11: strobes never overlap
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, sda_change, sda_sample}));

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .scl_out    (scl_out),
  .scl_fall   (scl_fall),
  .scl_rise   (scl_rise),
  .sda_change (sda_change),
  .sda_sample (sda_sample)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  localparam int CLK_P = 10;
  localparam int CW    = 10;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          pk_sel = 1'b0;
  logic [3*CW-1:0] cfg_word = '0;
  logic [DW-1:0] div_val = '0;
  logic [CW-1:0] high_val = '0;
  logic [CW-1:0] low_val = '0;
  logic [CW-1:0] cycle_val = '0;
  logic          stretch = 1'b0;
  logic          scl_in;
  logic          scl_out, scl_fall, scl_rise, sda_change, sda_sample;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign scl_in = scl_out & ~stretch;

  scl_timing_gen #(.CNT_W(CW), .DIV_W(DW)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (en),
    .cfg_packed_sel (pk_sel),
    .cfg_word       (cfg_word),
    .div_val        (div_val),
    .high_val       (high_val),
    .low_val        (low_val),
    .cycle_val      (cycle_val),
    .scl_in         (scl_in),
    .scl_out        (scl_out),
    .scl_fall       (scl_fall),
    .scl_rise       (scl_rise),
    .sda_change     (sda_change),
    .sda_sample     (sda_sample)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  function automatic int clamp2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // One enabled run of two periods; enable is dropped after the second fall.
  // s: cycles the line is held low after the first release (0 = none).
  // chg: new discrete high count applied after the first fall (-1 = none).
  task automatic run_case(input int d, input int h, input int l, input int c,
                          input bit pk, input int chg, input int s, input string tag);
    int de, hh, le, hh2;
    int nf, nr, nml, nmh;
    int tf1, tf2, tr1, tr2, tml1, tmh1, tmh2, endc;
    bit multi;
    de  = (d == 0) ? 1 : d;
    hh  = clamp2(h);
    le  = clamp2((h + l < c) ? (c - h) : l);
    hh2 = (chg >= 0) ? clamp2(chg) : hh;
    nf = 0; nr = 0; nml = 0; nmh = 0;
    tf1 = -1; tf2 = -1; tr1 = -1; tr2 = -1; tml1 = -1; tmh1 = -1; tmh2 = -1;
    endc = -1; multi = 1'b0;
    div_val = DW'(d);
    if (pk) begin
      pk_sel    = 1'b1;
      cfg_word  = {CW'(h), CW'(l), CW'(c)};
      high_val  = CW'(7);
      low_val   = CW'(2);
      cycle_val = CW'(31);
    end else begin
      pk_sel    = 1'b0;
      cfg_word  = {CW'(9), CW'(9), CW'(40)};
      high_val  = CW'(h);
      low_val   = CW'(l);
      cycle_val = CW'(c);
    end
    stretch = (s > 0);
    en = 1'b1;
    for (int cy = 1; cy <= 20000; cy++) begin
      @(negedge clk);
      if ((int'(scl_fall) + int'(scl_rise) + int'(sda_change) + int'(sda_sample)) > 1)
        multi = 1'b1;
      if (scl_fall) begin
        if (nf == 0) tf1 = cy; else if (nf == 1) tf2 = cy;
        nf++;
      end
      if (scl_rise) begin
        if (nr == 0) tr1 = cy; else if (nr == 1) tr2 = cy;
        nr++;
      end
      if (sda_change) begin
        if (nml == 0) tml1 = cy;
        nml++;
      end
      if (sda_sample) begin
        if (nmh == 0) tmh1 = cy; else if (nmh == 1) tmh2 = cy;
        nmh++;
      end
      if (nf >= 2) en = 1'b0;
      if (s > 0 && nr >= 1 && cy == tr1 + s) stretch = 1'b0;
      if (chg >= 0 && nf >= 1) high_val = CW'(chg);
      if (nmh >= 2 && endc < 0) endc = cy + hh2 * de + 4;
      if (endc > 0 && cy >= endc) break;
    end
    en = 1'b0;
    stretch = 1'b0;
    chk({tag, " R6 first fall one edge after enable"}, tf1, 1);
    chk({tag, " R7 mid-low strobe time"}, tml1, tf1 + (le / 2) * de);
    chk({tag, " R2 R3 low width"}, tr1, tf1 + le * de);
    chk({tag, " R7 R8 mid-high strobe time"}, tmh1, tr1 + s + (hh / 2) * de);
    chk({tag, " R4 R8 high width"}, tf2, tr1 + s + hh * de);
    chk({tag, " R3 second low width"}, tr2, tf2 + le * de);
    chk({tag, " R10 second-period mid-high"}, tmh2, tr2 + (hh2 / 2) * de);
    chk({tag, " R9 no fall after disable"}, nf, 2);
    chk({tag, " R9 line released when parked"}, int'(scl_out), 1);
    chk({tag, " R11 strobe overlap"}, int'(multi), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset line level", int'(scl_out), 1);
      chk("R1 reset strobes", int'({scl_fall, scl_rise, sda_change, sda_sample}), 0);
    end

    // near-exhaustive sweep of small settings, discrete inputs
    foreach (int_d[i]) ;
    for (int d = 0; d <= 3; d++)
      for (int hi = 0; hi < 3; hi++)
        for (int li = 0; li < 3; li++)
          for (int ci = 0; ci < 2; ci++) begin
            int h, l, c;
            h = (hi == 0) ? 1 : (hi == 1) ? 3 : 4;
            l = (li == 0) ? 1 : (li == 1) ? 3 : 6;
            c = (ci == 0) ? 0 : 12;
            run_case(d, h, l, c, 1'b0, -1, 0, "sweep");
          end

    // packed word presets (discrete inputs hold unrelated values)
    run_case(7, 10, 11, 26, 1'b1, -1, 0, "R5 preset-slow");
    run_case(2, 5, 12, 24, 1'b1, -1, 0, "R5 preset-fast");
    run_case(1, 3, 9, 18, 1'b1, -1, 0, "R5 preset-fastest");

    // mid-period change of the high count
    run_case(2, 3, 4, 0, 1'b0, 6, 0, "R10 change");
    run_case(1, 5, 3, 0, 1'b0, 2, 0, "R10 shrink");

    // target holding the clock low
    run_case(2, 4, 3, 0, 1'b0, -1, 7, "R8 stretch");
    run_case(1, 2, 2, 0, 1'b0, -1, 1, "R8 short-stretch");
    run_case(3, 5, 2, 14, 1'b0, -1, 20, "R8 long-stretch");

    summary();
    $finish;
  end

  int int_d[1];

endmodule